// File: doc/BRIEF.md
# Shared-Port Fetch Arbiter with Store-Conflict Flush

This block sits between a short in-order pipeline and a unified memory that has one synchronous port. Instruction fetch and data access both need that port. Each cycle the block gives the port to exactly one of them, or leaves it idle. It owns the sequential fetch address. When decode reports that the following cycle needs a data access, the block reserves that cycle. The data access always wins the port, so every load or store costs one fetch slot.

Stores go ahead on the assumption that they do not rewrite an instruction already fetched. The block remembers the word addresses fetched in the last few cycles, one entry per pipeline slot. It compares each store's word address with those entries. On a match it raises a one-cycle flush and gives the refetch address. It also moves its own fetch address there and drops the matching entry and everything fetched after it. This is the same recovery a pipeline uses for a mispredicted branch.

Read data from the memory is returned one cycle after the access. It goes to the fetch side or the data side, depending on who owned the port.

Top module: `shared_port_fetch_arb`

## Requirements
- R1: In any cycle the memory port carries at most one access. `mem_we_o` is high only in a cycle where a data request is present. A cycle used by a store produces no fetch response and no load response in the following cycle.
- R2: When `dat_req_i` is high, the port is given to data in that cycle. `mem_en_o` is 1, and `mem_addr_o`, `mem_we_o` and `mem_wdata_o` equal the data-side inputs. This holds whether or not fetch is enabled.
- R3: In the cycle after `dec_mem_i` was high, no fetch is issued, even if no data request arrives. `mem_en_o` is 0 in that case.
- R4: The first fetch after reset uses address `RESET_PC` (default 0). Each granted fetch advances the fetch address by 4. A cycle without a fetch grant leaves it unchanged. No fetch is issued while `fetch_en_i` is 0.
- R5: One cycle after a fetch grant, `if_valid_o` is 1, `if_addr_o` is the fetched address and `if_instr_o` is the memory read data. At all other times `if_valid_o` is 0.
- R6: One cycle after a load grant, `dat_rvalid_o` is 1 and `dat_rdata_o` carries the word read from the load address.
- R7: A store is compared with the fetches granted in the previous `DEPTH` cycles (default 4), bubbles included. If its word address (address bits above bit 1) equals one of them, `flush_o` is 1 in the following cycle. `flush_addr_o` is then the word address of the oldest matching entry with bits [1:0] zero.
- R8: The comparison ignores address bits [1:0], so a store to any byte of a fetched word conflicts. A store to a word not fetched in the window gives no flush. Loads never flush.
- R9: After a flush, the next granted fetch uses `flush_addr_o`. The matching entry and all younger entries are discarded. A store to the same word in the flush cycle therefore raises no further flush.
- R10: During and immediately after reset, `flush_o`, `if_valid_o` and `dat_rvalid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_en_i | input | 1 | Pipeline accepts a fetch this cycle |
| dec_mem_i | input | 1 | Decode saw a load/store; the next cycle is reserved for data |
| dat_req_i | input | 1 | Data access request this cycle |
| dat_we_i | input | 1 | Data access is a store |
| dat_addr_i | input | ADDR_W | Data byte address |
| dat_wdata_i | input | DATA_W | Store data |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle after a read |
| if_valid_o | output | 1 | Fetched instruction valid |
| if_addr_o | output | ADDR_W | Address of the fetched instruction |
| if_instr_o | output | DATA_W | Fetched instruction word |
| dat_rvalid_o | output | 1 | Load data valid |
| dat_rdata_o | output | DATA_W | Load data |
| flush_o | output | 1 | Store conflict detected; flush younger instructions |
| flush_addr_o | output | ADDR_W | Refetch address that goes with a flush |

## Verification
The bench runs a free-flowing fetch stream of six slots and then places one store at every word from the start of the stream to two words past its end. Each store is tried at every byte offset. This sweep separates words inside the four-slot window from words that left it long ago, from words never fetched, and from the byte-offset cases. The expected flush and refetch address follow from the slot arithmetic. Each conflicting store is followed by a second store to the same word. That case separates correct discarding of younger entries from a stale match. Separate runs try a load that arrives with no reservation, which shows that data wins the port and the fetch address is held, and a reservation with no data request, which shows that a bare bubble is produced.

// File: rtl/fa_pkg.sv
package fa_pkg;
  // Who holds the shared memory port in the current cycle.
  typedef enum logic [1:0] {
    OWN_IDLE  = 2'd0,
    OWN_FETCH = 2'd1,
    OWN_DATA  = 2'd2
  } port_owner_e;

  // Byte offset bits inside a 32-bit word; ignored by conflict checks.
  localparam int unsigned BYTE_OFS_W = 2;
  localparam int unsigned FETCH_STEP = 4;
endpackage

// File: rtl/fa_port_arb.sv
module fa_port_arb
  import fa_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch_en_i,
  input  logic        dec_mem_i,
  input  logic        dat_req_i,
  output port_owner_e owner_o
);
  logic resv_q, resv_d;
  logic resv_en;

  // The slot after a decoded memory instruction belongs to data.
  always_comb begin
    resv_d  = dec_mem_i;
    resv_en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_q <= 1'b0;
    end else if (resv_en) begin
      resv_q <= resv_d;
    end
  end

  // Data outranks fetch; a reserved slot is never given to fetch.
  always_comb begin
    if (dat_req_i) begin
      owner_o = OWN_DATA;
    end else if (fetch_en_i && !resv_q) begin
      owner_o = OWN_FETCH;
    end else begin
      owner_o = OWN_IDLE;
    end
  end
endmodule

// File: rtl/fa_fetch_pc.sv
module fa_fetch_pc
  import fa_pkg::*;
#(
  parameter int unsigned         ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]   RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(FETCH_STEP);

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              pc_en;

  always_comb begin
    pc_en = adv_i | load_i;
    if (load_i) begin
      pc_d = load_addr_i;
    end else begin
      pc_d = pc_q + STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/fa_inflight_trk.sv
module fa_inflight_trk
  import fa_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_vld_i,
  input  logic [ADDR_W-BYTE_OFS_W-1:0] push_word_i,
  input  logic                         chk_vld_i,
  input  logic [ADDR_W-BYTE_OFS_W-1:0] chk_word_i,
  output logic                         hit_o,
  output logic [ADDR_W-1:0]            hit_addr_o
);
  localparam int unsigned WORD_W = ADDR_W - BYTE_OFS_W;
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // Entry 0 is the youngest slot, entry DEPTH-1 the oldest.
  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [WORD_W-1:0] word_q [DEPTH];
  logic [WORD_W-1:0] word_d [DEPTH];
  logic [DEPTH-1:0]  match;
  logic [DEPTH-1:0]  kill;
  logic [IDX_W-1:0]  hit_idx;
  logic              hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = chk_vld_i & vld_q[g] & (word_q[g] == chk_word_i);
  end

  // Oldest match wins: scan upward, the last hit found is the highest index.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  // Discard the matching entry and every younger one.
  for (genvar g = 0; g < DEPTH; g++) begin : g_kill
    assign kill[g] = hit & (IDX_W'(g) <= hit_idx);
  end

  always_comb begin
    vld_d[0]  = push_vld_i;
    word_d[0] = push_word_i;
    for (int i = 1; i < DEPTH; i++) begin
      vld_d[i]  = vld_q[i-1] & ~kill[i-1];
      word_d[i] = word_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        word_q[i] <= '0;
      end
    end else begin
      vld_q <= vld_d;
      for (int i = 0; i < DEPTH; i++) begin
        word_q[i] <= word_d[i];
      end
    end
  end

  assign hit_o      = hit;
  assign hit_addr_o = {word_q[hit_idx], {BYTE_OFS_W{1'b0}}};
endmodule

// File: rtl/fa_resp_steer.sv
module fa_resp_steer
  import fa_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  port_owner_e       owner_i,
  input  logic              dat_we_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              if_valid_o,
  output logic [ADDR_W-1:0] if_addr_o,
  output logic [DATA_W-1:0] if_instr_o,
  output logic              dat_rvalid_o,
  output logic [DATA_W-1:0] dat_rdata_o
);
  logic              ifv_q, ifv_d;
  logic [ADDR_W-1:0] ifa_q, ifa_d;
  logic              ifa_en;
  logic              ldv_q, ldv_d;

  always_comb begin
    ifv_d  = (owner_i == OWN_FETCH);
    ifa_en = ifv_d;
    ifa_d  = pc_i;
    ldv_d  = (owner_i == OWN_DATA) & ~dat_we_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifv_q <= 1'b0;
      ldv_q <= 1'b0;
    end else begin
      ifv_q <= ifv_d;
      ldv_q <= ldv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifa_q <= '0;
    end else if (ifa_en) begin
      ifa_q <= ifa_d;
    end
  end

  assign if_valid_o   = ifv_q;
  assign if_addr_o    = ifa_q;
  assign if_instr_o   = mem_rdata_i;
  assign dat_rvalid_o = ldv_q;
  assign dat_rdata_o  = mem_rdata_i;
endmodule

// File: rtl/shared_port_fetch_arb.sv
module shared_port_fetch_arb
  import fa_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       DATA_W   = 32,
  parameter int unsigned       DEPTH    = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_en_i,
  input  logic              dec_mem_i,
  input  logic              dat_req_i,
  input  logic              dat_we_i,
  input  logic [ADDR_W-1:0] dat_addr_i,
  input  logic [DATA_W-1:0] dat_wdata_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              if_valid_o,
  output logic [ADDR_W-1:0] if_addr_o,
  output logic [DATA_W-1:0] if_instr_o,
  output logic              dat_rvalid_o,
  output logic [DATA_W-1:0] dat_rdata_o,
  output logic              flush_o,
  output logic [ADDR_W-1:0] flush_addr_o
);
  port_owner_e       owner;
  logic [ADDR_W-1:0] pc;
  logic              fetch_gnt;
  logic              store_gnt;
  logic              hit;
  logic [ADDR_W-1:0] hit_addr;
  logic              flush_q, flush_d;
  logic [ADDR_W-1:0] flush_addr_q;
  logic              flush_addr_en;

  fa_port_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_en_i (fetch_en_i),
    .dec_mem_i  (dec_mem_i),
    .dat_req_i  (dat_req_i),
    .owner_o    (owner)
  );

  assign fetch_gnt = (owner == OWN_FETCH);
  assign store_gnt = (owner == OWN_DATA) & dat_we_i;

  fa_fetch_pc #(
    .ADDR_W   (ADDR_W),
    .RESET_PC (RESET_PC)
  ) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_i       (fetch_gnt),
    .load_i      (hit),
    .load_addr_i (hit_addr),
    .pc_o        (pc)
  );

  fa_inflight_trk #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
  ) u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_vld_i  (fetch_gnt),
    .push_word_i (pc[ADDR_W-1:BYTE_OFS_W]),
    .chk_vld_i   (store_gnt),
    .chk_word_i  (dat_addr_i[ADDR_W-1:BYTE_OFS_W]),
    .hit_o       (hit),
    .hit_addr_o  (hit_addr)
  );

  fa_resp_steer #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_resp (
    .clk          (clk),
    .rst_n        (rst_n),
    .owner_i      (owner),
    .dat_we_i     (dat_we_i),
    .pc_i         (pc),
    .mem_rdata_i  (mem_rdata_i),
    .if_valid_o   (if_valid_o),
    .if_addr_o    (if_addr_o),
    .if_instr_o   (if_instr_o),
    .dat_rvalid_o (dat_rvalid_o),
    .dat_rdata_o  (dat_rdata_o)
  );

  // Memory port mux.
  always_comb begin
    mem_en_o    = (owner != OWN_IDLE);
    mem_we_o    = store_gnt;
    mem_addr_o  = (owner == OWN_DATA) ? dat_addr_i : pc;
    mem_wdata_o = dat_wdata_i;
  end

  // Flush notification, one cycle after the offending store.
  always_comb begin
    flush_d       = hit;
    flush_addr_en = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
    end else begin
      flush_q <= flush_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_addr_q <= '0;
    end else if (flush_addr_en) begin
      flush_addr_q <= hit_addr;
    end
  end

  assign flush_o      = flush_q;
  assign flush_addr_o = flush_addr_q;
endmodule

// File: rtl/fa_chk.sv
module fa_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_en_i,
  input logic              dec_mem_i,
  input logic              dat_req_i,
  input logic              dat_we_i,
  input logic [ADDR_W-1:0] dat_addr_i,
  input logic [DATA_W-1:0] dat_wdata_i,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              if_valid_o,
  input logic [ADDR_W-1:0] if_addr_o,
  input logic              dat_rvalid_o,
  input logic              flush_o,
  input logic [ADDR_W-1:0] flush_addr_o
);
  logic prev_dec_q;
  logic prev_store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_dec_q   <= 1'b0;
      prev_store_q <= 1'b0;
    end else begin
      prev_dec_q   <= dec_mem_i;
      prev_store_q <= mem_we_o;
    end
  end

  AST_WE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (dat_req_i && dat_we_i)); // R1

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(if_valid_o && dat_rvalid_o)); // R1

  AST_DATA_OWNS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    dat_req_i |-> (mem_en_o && mem_addr_o == dat_addr_i && mem_we_o == dat_we_i)); // R2

  AST_RESERVED_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_dec_q && !dat_req_i) |-> !mem_en_o); // R3

  AST_FETCH_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && !dat_req_i) |=> (if_valid_o && if_addr_o == $past(mem_addr_o))); // R5

  AST_LOAD_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_req_i && !dat_we_i) |=> dat_rvalid_o); // R6

  AST_FLUSH_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> prev_store_q); // R7

  AST_FLUSH_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (flush_addr_o[1:0] == 2'b00)); // R7

  AST_REFETCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_o && fetch_en_i && !dat_req_i) |-> (mem_en_o && mem_addr_o == flush_addr_o)); // R9
endmodule

bind shared_port_fetch_arb fa_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_en_i   (fetch_en_i),
  .dec_mem_i    (dec_mem_i),
  .dat_req_i    (dat_req_i),
  .dat_we_i     (dat_we_i),
  .dat_addr_i   (dat_addr_i),
  .dat_wdata_i  (dat_wdata_i),
  .mem_en_o     (mem_en_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .if_valid_o   (if_valid_o),
  .if_addr_o    (if_addr_o),
  .dat_rvalid_o (dat_rvalid_o),
  .flush_o      (flush_o),
  .flush_addr_o (flush_addr_o)
);

// File: tb/shared_port_fetch_arb_tb_top.sv
module shared_port_fetch_arb_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int F  = 6;

  logic          clk;
  logic          rst_n;
  logic          fetch_en, dec_mem, dat_req, dat_we;
  logic [AW-1:0] dat_addr;
  logic [DW-1:0] dat_wdata;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          if_valid;
  logic [AW-1:0] if_addr;
  logic [DW-1:0] if_instr;
  logic          dat_rvalid;
  logic [DW-1:0] dat_rdata;
  logic          flush;
  logic [AW-1:0] flush_addr;

  logic [DW-1:0] ram [64];

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  shared_port_fetch_arb dut_i (
    .clk (clk), .rst_n (rst_n),
    .fetch_en_i (fetch_en), .dec_mem_i (dec_mem),
    .dat_req_i (dat_req), .dat_we_i (dat_we),
    .dat_addr_i (dat_addr), .dat_wdata_i (dat_wdata),
    .mem_en_o (mem_en), .mem_we_o (mem_we),
    .mem_addr_o (mem_addr), .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .if_valid_o (if_valid), .if_addr_o (if_addr), .if_instr_o (if_instr),
    .dat_rvalid_o (dat_rvalid), .dat_rdata_o (dat_rdata),
    .flush_o (flush), .flush_addr_o (flush_addr)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Synchronous single-port memory model.
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr[7:2]] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr[7:2]];
    end
  end

  function automatic logic [31:0] pat(input int i);
    return 32'h5A00_0000 | 32'(i);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fetch_en = 1'b0; dec_mem = 1'b0; dat_req = 1'b0; dat_we = 1'b0;
    dat_addr = '0; dat_wdata = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    for (int i = 0; i < 64; i++) ram[i] = pat(i);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R10: outputs quiet right after reset; R4: no access without fetch_en
    chk(!flush && !if_valid && !dat_rvalid, "R10 reset state", {29'd0, flush, if_valid, dat_rvalid}, 32'd0);
    chk(!mem_en, "R4 idle without fetch_en", {31'd0, mem_en}, 32'd0);
  endtask

  task automatic sweep_case(input int w, input int b);
    bit conflict;
    logic [AW-1:0] saddr;
    do_reset();
    saddr    = AW'(4 * w + b);
    conflict = (w >= F - 4) && (w <= F - 1);
    for (int c = 0; c < F; c++) begin
      @(negedge clk);
      fetch_en = 1'b1; dat_req = 1'b0; dec_mem = (c == F - 1);
      #2;
      chk(mem_en && !mem_we && mem_addr == AW'(4 * c), "R4 sequential fetch", {16'd0, mem_addr}, 32'(4 * c));
      if (c > 0)
        chk(if_valid && if_addr == AW'(4 * (c - 1)) && if_instr == pat(c - 1),
            "R5 fetch response", if_instr, pat(c - 1));
    end
    // store cycle
    @(negedge clk);
    dec_mem = 1'b0; dat_req = 1'b1; dat_we = 1'b1; dat_addr = saddr; dat_wdata = 32'hDEAD_0000 | 32'(w);
    #2;
    chk(mem_en && mem_we && mem_addr == saddr && mem_wdata == dat_wdata, "R2 store owns port", {16'd0, mem_addr}, {16'd0, saddr});
    // cycle after store
    @(negedge clk);
    if (conflict) begin
      dat_req = 1'b1; dat_we = 1'b1; dat_addr = saddr;
    end else begin
      dat_req = 1'b0; dat_we = 1'b0;
    end
    #2;
    chk(flush == conflict, "R7 R8 flush decision", {31'd0, flush}, {31'd0, conflict});
    chk(!if_valid && !dat_rvalid, "R1 store slot gives no response", {30'd0, if_valid, dat_rvalid}, 32'd0);
    if (conflict) begin
      chk(flush_addr == AW'(4 * w), "R7 refetch address", {16'd0, flush_addr}, 32'(4 * w));
      @(negedge clk);
      dat_req = 1'b0; dat_we = 1'b0;
      #2;
      chk(!flush, "R9 killed entries do not match again", {31'd0, flush}, 32'd0);
      chk(mem_en && !mem_we && mem_addr == AW'(4 * w), "R9 fetch restarts at refetch address", {16'd0, mem_addr}, 32'(4 * w));
    end else begin
      chk(mem_en && !mem_we && mem_addr == AW'(4 * F), "R4 fetch held across store", {16'd0, mem_addr}, 32'(4 * F));
    end
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();

    // Load without reservation: data wins, fetch address held (R2, R4, R6, R8)
    do_reset();
    @(negedge clk);
    fetch_en = 1'b1; dat_req = 1'b1; dat_we = 1'b0; dat_addr = 16'h0020;
    #2;
    chk(mem_en && !mem_we && mem_addr == 16'h0020, "R2 load owns port", {16'd0, mem_addr}, 32'h20);
    @(negedge clk);
    dat_req = 1'b0;
    #2;
    chk(dat_rvalid && dat_rdata == pat(8), "R6 load response", dat_rdata, pat(8));
    chk(!if_valid, "R1 no fetch response after load slot", {31'd0, if_valid}, 32'd0);
    chk(!flush, "R8 load never flushes", {31'd0, flush}, 32'd0);
    chk(mem_en && mem_addr == 16'h0000, "R4 fetch held during load", {16'd0, mem_addr}, 32'h0);
    @(negedge clk);
    #2;
    chk(if_valid && if_addr == 16'h0000 && if_instr == pat(0), "R5 first fetch response", if_instr, pat(0));
    chk(!dat_rvalid, "R6 load valid lasts one cycle", {31'd0, dat_rvalid}, 32'd0);

    // Reservation without data request gives a bare bubble (R3)
    do_reset();
    @(negedge clk);
    fetch_en = 1'b1; dec_mem = 1'b1;
    #2;
    chk(mem_en && mem_addr == 16'h0000, "R4 fetch in decode cycle", {16'd0, mem_addr}, 32'h0);
    @(negedge clk);
    dec_mem = 1'b0;
    #2;
    chk(!mem_en, "R3 reserved slot stays idle", {31'd0, mem_en}, 32'd0);
    @(negedge clk);
    #2;
    chk(mem_en && mem_addr == 16'h0004, "R3 fetch resumes after bubble", {16'd0, mem_addr}, 32'h4);
    chk(!if_valid, "R5 bubble gives no response", {31'd0, if_valid}, 32'd0);

    // Store sweep over word position and byte offset (R7, R8, R9)
    for (int w = 0; w <= F + 1; w++) begin
      for (int b = 0; b < 4; b++) begin
        sweep_case(w, b);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R4 watchdog expired act=%0d exp=%0d", 20000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule